// File: doc/BRIEF.md
# Data Acquisition Register Front-End

This block is the byte-wide I/O-port register file of a multichannel analog acquisition card. A host addresses a small window with single-cycle read and write strobes. Through that window it sets the input channel range, the trigger source, the gain and polarity configuration and two 16-bit analog output words. It also reads back status, drives four digital output lines and samples four digital input lines. A write of any value to the data address starts a conversion. A frame timer then holds a busy flag for a programmable number of clock ticks. When the frame ends, a behavioural sample input stands in for the converter: the word for the selected channel is latched and can be read as two bytes.

The upper addresses of the window belong to a counter/timer core that lives outside this block. They stay hidden until the host writes a fixed three-step key into the high nibble of the configuration register. Once the key is accepted, accesses in the timer range raise a select pulse and reads return the timer core's byte.

The host bus is plain: there is no back-pressure. A write completes on the clock edge where it is sampled. A read returns data with a one-cycle valid pulse.

Top module: `daq_reg_frontend`

## Requirements
- R1: After reset, the configuration, control and channel registers read 0. Both analog output words are 0, the digital outputs are 0, the busy flag is 0 and the timer bank is hidden.
- R2: `bus_rvalid` pulses exactly one cycle after `bus_rd`, and `bus_rdata` carries the addressed byte in that cycle. Unmapped or write-only addresses read 0x00.
- R3: A write to offset 0x00 while idle raises `conv_busy` from the next cycle. The flag stays high for `frame_len`+1 cycles.
- R4: A write to offset 0x00 while `conv_busy` is high is ignored and does not lengthen the frame.
- R5: At the end of a frame, the sample word indexed by channel-select bits 3:0 is latched; in differential mode (`diff_mode`=1) the index is taken modulo 8. The low byte reads at 0x00 and the high byte at 0x01.
- R6: Status at 0x08 reads busy in bit 7, `diff_mode` in bit 5 and 0 elsewhere. Writes to it have no effect.
- R7: Configuration at 0x11 is read/write. Bits 1:0 drive `gain` (0..3 for x1, x2, x4, x8) and bit 2 drives `unipolar` (0 bipolar, 1 unipolar).
- R8: Control at 0x09 is read/write, and its bits 1:0 drive `trig_src` (0 is software trigger).
- R9: Analog output words are write-only byte pairs, low byte at the even address and high byte at the odd address. 0x04/0x05 form `dac0` and 0x06/0x07 form `dac1`. Each output updates the cycle after its write.
- R10: Offset 0x03 reads `din` in bits 3:0 with the upper bits 0. A write there drives `dout` from data bits 3:0.
- R11: The timer bank becomes visible only after three consecutive configuration writes whose bits 7:4 are 0x3, 0xB, 0xA in that order. Any other order leaves it hidden. Once visible, it stays visible until reset.
- R12: With the bank visible, an access to 0x12..0x15 pulses `tmr_sel` in the same cycle and reads return `tmr_rdata`. With it hidden there is no pulse and reads return 0.
- R13: Channel select at 0x02 is read/write and reads back the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one tick per frame-timer step) |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| frame_len | input | 16 | Frame count; busy lasts frame_len+1 cycles |
| samples | input | 256 | Behavioural converter inputs, 16 words of 16 bits |
| diff_mode | input | 1 | Input mode: 1 differential, 0 single-ended |
| din | input | 4 | Digital input lines |
| dout | output | 4 | Digital output lines |
| dac0 | output | 16 | Analog output word 0 |
| dac1 | output | 16 | Analog output word 1 |
| gain | output | 2 | Gain code |
| unipolar | output | 1 | Polarity select |
| trig_src | output | 2 | Trigger source code |
| conv_busy | output | 1 | Conversion in progress |
| tmr_bank_en | output | 1 | Timer bank visible |
| tmr_sel | output | 1 | Access to timer range while visible |
| tmr_rdata | input | 8 | Byte returned by the timer core |

## Verification
Register outputs (`dac0`, `dac1`, `gain`, `unipolar`, `trig_src`, `dout`, `tmr_bank_en`) change at the edge that samples the write, so the bench drives on a falling edge and checks at the next falling edge. Read data arrives one edge after the read strobe and is checked at the falling edge where `bus_rvalid` is high. The busy window is measured with a cycle counter: it starts at the edge that takes the strobe and ends at the falling edge where busy is first seen low, and that length must equal `frame_len`+1. The latched sample is read only after busy has dropped.

// File: rtl/daq_fe_pkg.sv
package daq_fe_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_DATA_LO = 5'h00;
  localparam logic [ADDR_W-1:0] A_DATA_HI = 5'h01;
  localparam logic [ADDR_W-1:0] A_CHAN    = 5'h02;
  localparam logic [ADDR_W-1:0] A_DIO     = 5'h03;
  localparam logic [ADDR_W-1:0] A_DAC0_LO = 5'h04;
  localparam logic [ADDR_W-1:0] A_DAC0_HI = 5'h05;
  localparam logic [ADDR_W-1:0] A_DAC1_LO = 5'h06;
  localparam logic [ADDR_W-1:0] A_DAC1_HI = 5'h07;
  localparam logic [ADDR_W-1:0] A_STAT    = 5'h08;
  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h09;
  localparam logic [ADDR_W-1:0] A_CFG     = 5'h11;
  localparam logic [ADDR_W-1:0] A_TMR_LO  = 5'h12;
  localparam logic [ADDR_W-1:0] A_TMR_HI  = 5'h15;

  typedef enum logic [1:0] {UL_IDLE, UL_KEY1, UL_KEY2} unlock_t;
endpackage

// File: rtl/daq_bank_unlock.sv
module daq_bank_unlock #(
  parameter logic [3:0] KEY1 = 4'h3,
  parameter logic [3:0] KEY2 = 4'hB,
  parameter logic [3:0] KEY3 = 4'hA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [3:0] nib,
  output logic       bank_en
);
  import daq_fe_pkg::*;
  unlock_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= UL_IDLE;
      bank_en <= 1'b0;
    end else if (cfg_wr) begin
      unique case (st_q)
        UL_KEY1: st_q <= (nib == KEY2) ? UL_KEY2 : ((nib == KEY1) ? UL_KEY1 : UL_IDLE);
        UL_KEY2: begin
          if (nib == KEY3) begin
            bank_en <= 1'b1;
            st_q    <= UL_IDLE;
          end else begin
            st_q <= (nib == KEY1) ? UL_KEY1 : UL_IDLE;
          end
        end
        default: st_q <= (nib == KEY1) ? UL_KEY1 : UL_IDLE;
      endcase
    end
  end

  // R11
  bank_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_en |=> bank_en);
  // R11
  bank_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bank_en) |-> $past(cfg_wr && nib == KEY3));
endmodule

// File: rtl/daq_conv_timer.sv
module daq_conv_timer #(
  parameter int FRAME_W = 16,
  parameter int NCH     = 16,
  parameter int SAMP_W  = 16,
  localparam int IDX_W  = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_W-1:0]    frame_len,
  input  logic [IDX_W-1:0]      sel_idx,
  input  logic [NCH*SAMP_W-1:0] samples,
  output logic                  busy,
  output logic [SAMP_W-1:0]     data
);
  logic [FRAME_W-1:0] cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [SAMP_W-1:0]  pick;

  always_comb pick = samples[idx_q*SAMP_W +: SAMP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      idx_q <= '0;
      data  <= '0;
    end else if (busy) begin
      if (cnt_q == '0) begin
        busy <= 1'b0;
        data <= pick;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= frame_len;
      idx_q <= sel_idx;
    end
  end

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> busy);
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  // R4
  strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(data));
endmodule

// File: rtl/daq_reg_frontend.sv
module daq_reg_frontend #(
  parameter int FRAME_W = 16,
  parameter int NCH     = 16,
  parameter int SAMP_W  = 16,
  parameter int DIO_W   = 4,
  localparam int IDX_W  = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic                  bus_rvalid,
  input  logic [FRAME_W-1:0]    frame_len,
  input  logic [NCH*SAMP_W-1:0] samples,
  input  logic                  diff_mode,
  input  logic [DIO_W-1:0]      din,
  output logic [DIO_W-1:0]      dout,
  output logic [15:0]           dac0,
  output logic [15:0]           dac1,
  output logic [1:0]            gain,
  output logic                  unipolar,
  output logic [1:0]            trig_src,
  output logic                  conv_busy,
  output logic                  tmr_bank_en,
  output logic                  tmr_sel,
  input  logic [7:0]            tmr_rdata
);
  import daq_fe_pkg::*;

  logic [7:0]        chan_q, ctrl_q, cfg_q;
  logic [SAMP_W-1:0] adc_word;
  logic [IDX_W-1:0]  sel_idx;
  logic              in_tmr, wr_strobe, wr_cfg;
  logic [7:0]        rd_mux;

  always_comb begin
    in_tmr    = (bus_addr >= A_TMR_LO) && (bus_addr <= A_TMR_HI);
    tmr_sel   = (bus_wr || bus_rd) && in_tmr && tmr_bank_en;
    wr_strobe = bus_wr && (bus_addr == A_DATA_LO);
    wr_cfg    = bus_wr && (bus_addr == A_CFG);
    sel_idx   = chan_q[IDX_W-1:0];
    if (diff_mode) sel_idx[IDX_W-1] = 1'b0;
    gain      = cfg_q[1:0];
    unipolar  = cfg_q[2];
    trig_src  = ctrl_q[1:0];
  end

  daq_conv_timer #(.FRAME_W(FRAME_W), .NCH(NCH), .SAMP_W(SAMP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_strobe), .frame_len(frame_len),
    .sel_idx(sel_idx), .samples(samples), .busy(conv_busy), .data(adc_word));

  daq_bank_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr_cfg), .nib(bus_wdata[7:4]),
    .bank_en(tmr_bank_en));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= '0;
      ctrl_q <= '0;
      cfg_q  <= '0;
      dac0   <= '0;
      dac1   <= '0;
      dout   <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_CHAN:    chan_q     <= bus_wdata;
        A_DIO:     dout       <= bus_wdata[DIO_W-1:0];
        A_DAC0_LO: dac0[7:0]  <= bus_wdata;
        A_DAC0_HI: dac0[15:8] <= bus_wdata;
        A_DAC1_LO: dac1[7:0]  <= bus_wdata;
        A_DAC1_HI: dac1[15:8] <= bus_wdata;
        A_CTRL:    ctrl_q     <= bus_wdata;
        A_CFG:     cfg_q      <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    unique case (bus_addr)
      A_DATA_LO: rd_mux = adc_word[7:0];
      A_DATA_HI: rd_mux = adc_word[15:8];
      A_CHAN:    rd_mux = chan_q;
      A_DIO:     rd_mux = 8'(din);
      A_STAT:    rd_mux = {conv_busy, 1'b0, diff_mode, 5'b0};
      A_CTRL:    rd_mux = ctrl_q;
      A_CFG:     rd_mux = cfg_q;
      default:   rd_mux = (in_tmr && tmr_bank_en) ? tmr_rdata : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R2
  rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd));
  // R12
  tmr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_sel |-> tmr_bank_en);
  // R9
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(dac0) && $stable(dac1)));
endmodule

// File: tb/daq_reg_frontend_tb.sv
module daq_reg_frontend_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [15:0] frame_len = 16'd5;
  logic [255:0] samples;
  logic        diff_mode = 1'b0;
  logic [3:0]  din = 4'h9;
  logic [3:0]  dout;
  logic [15:0] dac0, dac1;
  logic [1:0]  gain, trig_src;
  logic        unipolar, conv_busy, tmr_bank_en, tmr_sel;
  logic [7:0]  tmr_rdata = 8'h5A;
  int errors = 0, checks = 0, cyc = 0;
  logic        sel_seen;

  daq_reg_frontend u_dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (tmr_sel) sel_seen <= 1'b1;

  initial for (int i = 0; i < 16; i++) samples[i*16 +: 16] = 16'hA000 + 16'(i * 16'h0111);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk("R2 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  // entry: {addr, write data, expected read}
  localparam logic [20:0] VEC [0:7] = '{
    {5'h02, 8'h37, 8'h37},   // R13
    {5'h09, 8'hFD, 8'hFD},   // R8
    {5'h11, 8'h06, 8'h06},   // R7
    {5'h08, 8'hFF, 8'h00},   // R6 write ignored
    {5'h04, 8'h12, 8'h00},   // R9 write-only
    {5'h03, 8'hF5, 8'h09},   // R10 reads din
    {5'h0C, 8'h77, 8'h00},   // R2 unmapped
    {5'h13, 8'h44, 8'h00}    // R12 hidden bank
  };

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r, lo, hi;
    int c0, len;
    sel_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dac0", 32'(dac0), 0); chk("R1 dac1", 32'(dac1), 0);
    chk("R1 gain", 32'(gain), 0); chk("R1 trig", 32'(trig_src), 0);
    chk("R1 busy", 32'(conv_busy), 0); chk("R1 bank", 32'(tmr_bank_en), 0);
    chk("R1 dout", 32'(dout), 0);
    rd(5'h11, r); chk("R1 cfg", 32'(r), 0);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][20:16], VEC[i][15:8]);
      rd(VEC[i][20:16], r);
      chk($sformatf("R2 vec%0d", i), 32'(r), 32'(VEC[i][7:0]));
    end
    chk("R12 no sel hidden", 32'(sel_seen), 0);
    chk("R7 gain", 32'(gain), 2); chk("R7 unipolar", 32'(unipolar), 1);
    chk("R8 trig", 32'(trig_src), 1);
    chk("R10 dout", 32'(dout), 5);

    // R9 byte lanes
    wr(5'h04, 8'h34); wr(5'h05, 8'h12); chk("R9 dac0", 32'(dac0), 32'h1234);
    wr(5'h06, 8'hCD); wr(5'h07, 8'hAB); chk("R9 dac1", 32'(dac1), 32'hABCD);

    // R3 busy length, R5 single-ended channel 13
    wr(5'h02, 8'hDD);
    wr(5'h00, 8'h00); c0 = cyc;
    rd(5'h08, r); chk("R6 status busy", 32'(r), 32'h80);
    while (conv_busy) @(negedge clk);
    len = cyc - c0; chk("R3 busy length", 32'(len), 6);
    rd(5'h00, lo); rd(5'h01, hi);
    chk("R5 single-ended", 32'({hi, lo}), 32'(16'hA000 + 16'd13 * 16'h0111));

    // R4 strobe while busy, R5 differential modulo 8
    diff_mode = 1'b1;
    wr(5'h00, 8'h00); c0 = cyc;
    wr(5'h00, 8'h00);
    while (conv_busy) @(negedge clk);
    len = cyc - c0; chk("R4 ignored strobe", 32'(len), 6);
    rd(5'h00, lo); rd(5'h01, hi);
    chk("R5 differential", 32'({hi, lo}), 32'(16'hA000 + 16'd5 * 16'h0111));
    rd(5'h08, r); chk("R6 status diff", 32'(r), 32'h20);

    // R3 minimum frame
    frame_len = 16'd0;
    wr(5'h00, 8'h00); c0 = cyc;
    while (conv_busy) @(negedge clk);
    len = cyc - c0; chk("R3 single-tick frame", 32'(len), 1);

    // R11 wrong orders
    wr(5'h11, 8'hB0); wr(5'h11, 8'h30); wr(5'h11, 8'hA0);
    wr(5'h11, 8'h30); wr(5'h11, 8'hA0); wr(5'h11, 8'hB0);
    chk("R11 wrong order", 32'(tmr_bank_en), 0);
    rd(5'h12, r); chk("R12 hidden read", 32'(r), 0);
    // R11 correct key (repeated first key restarts)
    wr(5'h11, 8'h30); wr(5'h11, 8'h30); wr(5'h11, 8'hB0); wr(5'h11, 8'hA1);
    chk("R11 unlocked", 32'(tmr_bank_en), 1);
    chk("R7 gain after key", 32'(gain), 1);
    rd(5'h12, r); chk("R12 timer read", 32'(r), 32'h5A);
    chk("R12 sel seen", 32'(sel_seen), 1);
    wr(5'h11, 8'h00); chk("R11 sticky", 32'(tmr_bank_en), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule